// File: doc/BRIEF.md
# Paired-Sample Recognizer with Hold Qualifier

This block watches two single-bit inputs on every rising clock edge and raises a single flag. The flag goes high once the first input, `a_in`, has shown the same value on two consecutive edges. Once high, the flag stays up while the second input, `b_in`, is sampled as 1 on each later edge, even if `a_in` changes. The flag drops on the first edge where `a_in` differs from its previous sample and `b_in` is 0. Any edge where `a_in` repeats its previous value sets the flag again, whatever `b_in` is.

The machine is Moore-style. The flag is decoded only from a three-bit registered state, so input changes between edges never reach the output directly. The five live state codes are fixed. The upper two bits mark the "satisfied" states, and the low bit records the last `a_in` value. Any other code falls back to the idle code on the next edge.

Top module: `pair_hist_recognizer`

## Requirements
- R1: An edge with `rst` at 1 puts the machine in its idle state (code 000) and `z_out` reads 0 after that edge. Reset takes priority over the data inputs.
- R2: `z_out` changes only on rising clock edges. Changing `a_in` or `b_in` between edges leaves `z_out` unchanged.
- R3: The first edge after reset can never set `z_out`, because no earlier sample of `a_in` exists.
- R4: If `a_in` is sampled at the same value (both 0 or both 1) on two consecutive edges since reset, `z_out` is 1 after the second of those edges.
- R5: While `z_out` is 1, an edge with `b_in` at 1 keeps `z_out` at 1, even when `a_in` differs from its previous sample.
- R6: While `z_out` is 1, an edge where `a_in` differs from its previous sample and `b_in` is 0 clears `z_out`.
- R7: While `z_out` is 0, an edge where `a_in` differs from its previous sample leaves `z_out` at 0, whatever `b_in` is.
- R8: While `z_out` is 1, an edge where `a_in` repeats its previous sample keeps `z_out` at 1, whatever `b_in` is.
- R9: Asserting reset while `z_out` is 1 clears it at the next edge, even when the inputs would otherwise keep it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Sample compared against its previous value |
| b_in | input | 1 | Hold qualifier for a set flag |
| z_out | output | 1 | Registered recognizer flag |

## Verification
The equal-pair rule and the B-hold rule can both apply on the same edge. This happens when the flag is already set, `a_in` repeats and `b_in` is 1. It also happens in the harder case where `a_in` flips while `b_in` is 1, and the flag must survive by the hold rule alone. An exhaustive sweep of every six-edge input sequence after reset produces all of these overlaps. A reference model judges each edge by the rule statement: the flag is set if there was an equal pair, or if the flag was already set and `b_in` is 1. Directed steps also assert reset on an edge where both rules would keep the flag set, and reset must win.

// File: rtl/rec_pkg.sv
package rec_pkg;

    localparam int STATE_W = 3;
    localparam int SAT_HI  = STATE_W - 1;
    localparam int SAT_LO  = STATE_W - 2;
    localparam int LAST_A  = 0;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_SEEN0 = 3'b100,
        ST_SEEN1 = 3'b101,
        ST_HELD0 = 3'b110,
        ST_HELD1 = 3'b111
    } rec_state_e;

    // Next state from a raw code; unused codes fall back to idle.
    function automatic logic [STATE_W-1:0] next_code(
        input logic [STATE_W-1:0] cur,
        input logic               a,
        input logic               b
    );
        logic [STATE_W-1:0] nxt;
        case (cur)
            ST_IDLE:  nxt = a ? ST_SEEN1 : ST_SEEN0;
            ST_SEEN0: nxt = a ? ST_SEEN1 : ST_HELD0;
            ST_SEEN1: nxt = a ? ST_HELD1 : ST_SEEN0;
            ST_HELD0: nxt = !a ? ST_HELD0 : (b ? ST_HELD1 : ST_SEEN1);
            ST_HELD1: nxt = a ? ST_HELD1 : (b ? ST_HELD0 : ST_SEEN0);
            default:  nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rec_next_logic.sv
module rec_next_logic
    import rec_pkg::*;
(
    input  logic [STATE_W-1:0] cur_code,
    input  logic               a_bit,
    input  logic               b_bit,
    output logic [STATE_W-1:0] nxt_code
);
    always_comb begin
        nxt_code = next_code(cur_code, a_bit, b_bit);
    end
endmodule

// File: rtl/rec_state_reg.sv
module rec_state_reg
    import rec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] d_code,
    output logic [STATE_W-1:0] q_code
);
    // One D flip-flop per state bit; reset value is the idle code.
    localparam logic [STATE_W-1:0] RST_CODE = ST_IDLE;

    for (genvar gi = 0; gi < STATE_W; gi++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q_code[gi] <= RST_CODE[gi];
            else     q_code[gi] <= d_code[gi];
        end
    end
endmodule

// File: rtl/rec_out_decode.sv
module rec_out_decode (
    input  logic hi_bit,
    input  logic lo_bit,
    output logic flag
);
    // Satisfied states are exactly those with both upper bits set.
    always_comb begin
        flag = hi_bit & lo_bit;
    end
endmodule

// File: rtl/pair_hist_recognizer.sv
module pair_hist_recognizer
    import rec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_in,
    input  logic b_in,
    output logic z_out
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    rec_next_logic u_next (
        .cur_code (state_q),
        .a_bit    (a_in),
        .b_bit    (b_in),
        .nxt_code (state_d)
    );

    rec_state_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .d_code (state_d),
        .q_code (state_q)
    );

    rec_out_decode u_out (
        .hi_bit (state_q[SAT_HI]),
        .lo_bit (state_q[SAT_LO]),
        .flag   (z_out)
    );

    // R3: leaving idle never yields a set flag
    a_r3_idle_no_set: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !z_out);

    // R4: a repeated sample of a_in sets the flag
    a_r4_pair_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEEN0 && !a_in) |=> z_out);
    a_r4_pair_one: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEEN1 && a_in) |=> z_out);

    // R5: b_in held high keeps a set flag
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (z_out && b_in) |=> z_out);

    // R6: a_in change with b_in low drops the flag
    a_r6_drop: assert property (@(posedge clk) disable iff (rst)
        (z_out && !b_in && (a_in != state_q[LAST_A])) |=> !z_out);

    // R7: a change while clear keeps the flag clear
    a_r7_stay_clear: assert property (@(posedge clk) disable iff (rst)
        (!z_out && state_q != ST_IDLE && (a_in != state_q[LAST_A])) |=> !z_out);

    // R8: a repeat while set keeps the flag set
    a_r8_repeat_keep: assert property (@(posedge clk) disable iff (rst)
        (z_out && (a_in == state_q[LAST_A])) |=> z_out);
endmodule

// File: tb/tb_pair_hist_recognizer.sv
`timescale 1ns/1ps
module tb_pair_hist_recognizer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic z_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model
    bit m_valid = 1'b0;
    bit m_last = 1'b0;
    bit m_z = 1'b0;

    always #4 clk = ~clk;

    pair_hist_recognizer dut (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in),
        .b_in  (b_in),
        .z_out (z_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: z_out=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; leaves at a negedge
    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_valid = 1'b0;
        m_z = 1'b0;
        check("R1", z_out, 1'b0);
    endtask

    task automatic step(input logic a, input logic b);
        string tag;
        bit nz;
        bit pair;
        a_in = a;
        b_in = b;
        pair = m_valid && (a == m_last);
        if (!m_valid)      tag = "R3";
        else if (pair)     tag = m_z ? "R8" : "R4";
        else if (m_z && b) tag = "R5";
        else if (m_z)      tag = "R6";
        else               tag = "R7";
        nz = pair || (m_z && b);
        @(posedge clk);
        m_last = a;
        m_valid = 1'b1;
        m_z = nz;
        @(negedge clk);
        check(tag, z_out, m_z);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // directed: set via pair of ones, then probe mid-cycle stability
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check("R4", z_out, 1'b1);
        a_in = 1'b0;
        b_in = 1'b0;
        #1;
        check("R2", z_out, 1'b1);
        a_in = 1'b1;
        b_in = 1'b1;
        #1;
        check("R2", z_out, 1'b1);
        #1;
        // R9: reset wins while repeat and hold both apply
        a_in = 1'b1;
        b_in = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", z_out, 1'b0);
        rst = 1'b0;
        m_valid = 1'b0;
        m_z = 1'b0;

        // directed: hold through changes, then drop
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);

        // exhaustive sweep of six-edge sequences after reset
        for (int s = 0; s < 4096; s++) begin
            do_reset();
            for (int k = 0; k < 6; k++) begin
                step(logic'((s >> (2 * k)) & 1), logic'((s >> (2 * k + 1)) & 1));
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule